// File: doc/BRIEF.md
# Connectivity-Aware Dimension-Order Route Unit

This unit is the route computation stage of one switch in a wormhole-switched 2D mesh. The mesh may have been cut down to an irregular region, as long as every row and every column of that region is contiguous. For each packet it takes the destination coordinates from the head flit and compares them with the switch's own coordinates. It returns one output port, one-hot over north, south, east, west and local ejection.

Two link-presence bits steer the order of dimensions at this switch, one for the north neighbour and one for the south neighbour. A vertical step is taken only when the link toward the destination row exists. Otherwise the packet moves sideways toward the destination column. This gives Y-first routing where the region allows it and X-first routing where it does not, with no table. The coordinates and the two link bits are loaded once, when the region is set up. The route picked on the head flit stays on the output for the body and tail flits of the same packet.

Top module: `conn_route_unit`

## Requirements
- R1: When the destination row is below the current row (dst_y < cur_y) and the south link bit is 1, the route is south (route_oh bit 1).
- R2: When R1 does not apply, the destination row is above the current row (dst_y > cur_y) and the north link bit is 1, the route is north (route_oh bit 0).
- R3: When no vertical move is selected, a destination column to the east (dst_x > cur_x) selects east (bit 2) and one to the west selects west (bit 3).
- R4: When both coordinates match, the route is local (bit 4). When only the row differs and its vertical link is absent, the vertical port toward the destination is still selected.
- R5: A route is presented with route_valid only while a flit is valid. Whenever route_valid is 1, exactly one route_oh bit is set. A body flit (kind 00) or tail flit (kind 10) that arrives outside a packet produces no route.
- R6: A head flit (kind 01) that is accepted (flit_valid and flit_ready both 1) opens a packet and raises pkt_open in the next cycle. Until the packet closes, every valid flit shows the head's route, whatever its header fields hold.
- R7: An accepted flit of kind tail (10) or head+tail (11) closes the open packet, and pkt_open falls in the next cycle.
- R8: A head+tail flit (kind 11) arriving outside a packet is routed but opens no packet. A head flit that is not accepted (flit_ready 0) opens no packet.
- R9: A configuration write (cfg_we) updates the coordinates and link bits for flits from the next cycle on, but has no effect while pkt_open is 1.
- R10: After reset no packet is open, the coordinates are (0,0) and both link bits are 0.
- R11: When each switch of a row- and column-contiguous region is configured with its own coordinates and the true presence of its north and south links, hop-by-hop routing between any two nodes stays inside the region. It reaches the destination in a number of hops equal to the Manhattan distance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_x | input | CW (4) | Column coordinate of this switch |
| cfg_y | input | CW (4) | Row coordinate of this switch |
| cfg_link_n | input | 1 | 1 when the north neighbour link exists |
| cfg_link_s | input | 1 | 1 when the south neighbour link exists |
| flit_valid | input | 1 | A flit is presented this cycle |
| flit_ready | input | 1 | The downstream stage accepts the presented flit |
| flit_kind | input | 2 | 00 body, 01 head, 10 tail, 11 head+tail |
| flit_dst_x | input | CW (4) | Destination column from the header |
| flit_dst_y | input | CW (4) | Destination row from the header |
| route_oh | output | 5 | One-hot port: bit0 N, bit1 S, bit2 E, bit3 W, bit4 L |
| route_valid | output | 1 | route_oh is meaningful this cycle |
| pkt_open | output | 1 | A packet is in progress and its route is held |

## Verification
A corrupted held route would show on the first body flit after the head: route_oh would move away from the port the head chose. A stuck packet flag would show either as body flits with no route or as a head+tail flit that leaves pkt_open high in the next cycle. A wrong coordinate or link register would send a hop out of the region, or would stretch a path beyond the Manhattan distance within the first few hops of the walk. Configuration written during a packet would show up on the first head routed after the tail.

// File: rtl/croute_pkg.sv
package croute_pkg;

    localparam int unsigned NUM_PORTS = 5;
    localparam int unsigned PORT_N    = 0;
    localparam int unsigned PORT_S    = 1;
    localparam int unsigned PORT_E    = 2;
    localparam int unsigned PORT_W    = 3;
    localparam int unsigned PORT_L    = 4;

    typedef logic [NUM_PORTS-1:0] port_oh_t;

    // bit0: flit starts a packet, bit1: flit ends a packet
    typedef enum logic [1:0] {
        FLIT_BODY = 2'b00,
        FLIT_HEAD = 2'b01,
        FLIT_TAIL = 2'b10,
        FLIT_SOLO = 2'b11
    } flit_kind_e;

    function automatic logic opens_pkt(input logic [1:0] kind);
        return kind[0];
    endfunction

    function automatic logic closes_pkt(input logic [1:0] kind);
        return kind[1];
    endfunction

    function automatic port_oh_t port_bit(input int unsigned idx);
        port_oh_t v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/croute_cfg.sv
module croute_cfg #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          locked,
    input  logic [CW-1:0] wr_x,
    input  logic [CW-1:0] wr_y,
    input  logic          wr_link_n,
    input  logic          wr_link_s,
    output logic [CW-1:0] cur_x,
    output logic [CW-1:0] cur_y,
    output logic          link_n,
    output logic          link_s
);

    typedef struct packed {
        logic [CW-1:0] x;
        logic [CW-1:0] y;
        logic          n;
        logic          s;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && !locked) begin
            cfg_d.x = wr_x;
            cfg_d.y = wr_y;
            cfg_d.n = wr_link_n;
            cfg_d.s = wr_link_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cur_x  = cfg_q.x;
    assign cur_y  = cfg_q.y;
    assign link_n = cfg_q.n;
    assign link_s = cfg_q.s;

endmodule

// File: rtl/croute_decide.sv
module croute_decide
    import croute_pkg::*;
#(
    parameter int unsigned CW = 4
) (
    input  logic [CW-1:0] dst_x,
    input  logic [CW-1:0] dst_y,
    input  logic [CW-1:0] cur_x,
    input  logic [CW-1:0] cur_y,
    input  logic          link_n,
    input  logic          link_s,
    output port_oh_t      route
);

    typedef struct packed {
        logic y_lo;
        logic y_hi;
        logic x_lo;
        logic x_hi;
    } cmp_t;

    cmp_t     cmp;
    port_oh_t route_d;

    always_comb begin
        cmp.y_lo = (dst_y < cur_y);
        cmp.y_hi = (dst_y > cur_y);
        cmp.x_lo = (dst_x < cur_x);
        cmp.x_hi = (dst_x > cur_x);

        // priority: south, north, east, west, then column reached
        if (cmp.y_lo && link_s) begin
            route_d = port_bit(PORT_S);
        end else if (cmp.y_hi && link_n) begin
            route_d = port_bit(PORT_N);
        end else if (cmp.x_hi) begin
            route_d = port_bit(PORT_E);
        end else if (cmp.x_lo) begin
            route_d = port_bit(PORT_W);
        end else if (cmp.y_lo) begin
            route_d = port_bit(PORT_S);
        end else if (cmp.y_hi) begin
            route_d = port_bit(PORT_N);
        end else begin
            route_d = port_bit(PORT_L);
        end
    end

    assign route = route_d;

endmodule

// File: rtl/croute_hold.sv
module croute_hold
    import croute_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flit_valid,
    input  logic       flit_ready,
    input  logic [1:0] flit_kind,
    input  port_oh_t   fresh_route,
    output port_oh_t   route_oh,
    output logic       route_valid,
    output logic       open
);

    typedef struct packed {
        logic     open;
        port_oh_t held;
    } hold_t;

    hold_t    st_d, st_q;
    logic     accept;
    port_oh_t out_route;
    logic     out_valid;

    always_comb begin
        st_d      = st_q;
        accept    = flit_valid && flit_ready;
        out_valid = 1'b0;
        out_route = '0;
        if (!st_q.open) begin
            if (flit_valid && opens_pkt(flit_kind)) begin
                out_valid = 1'b1;
                out_route = fresh_route;
            end
            if (accept && flit_kind == FLIT_HEAD) begin
                st_d.open = 1'b1;
                st_d.held = fresh_route;
            end
        end else begin
            out_valid = flit_valid;
            out_route = flit_valid ? st_q.held : '0;
            if (accept && closes_pkt(flit_kind)) begin
                st_d.open = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign route_oh    = out_route;
    assign route_valid = out_valid;
    assign open        = st_q.open;

endmodule

// File: rtl/conn_route_unit.sv
module conn_route_unit
    import croute_pkg::*;
#(
    parameter int unsigned CW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CW-1:0]        cfg_x,
    input  logic [CW-1:0]        cfg_y,
    input  logic                 cfg_link_n,
    input  logic                 cfg_link_s,
    input  logic                 flit_valid,
    input  logic                 flit_ready,
    input  logic [1:0]           flit_kind,
    input  logic [CW-1:0]        flit_dst_x,
    input  logic [CW-1:0]        flit_dst_y,
    output logic [NUM_PORTS-1:0] route_oh,
    output logic                 route_valid,
    output logic                 pkt_open
);

    logic [CW-1:0] cur_x;
    logic [CW-1:0] cur_y;
    logic          link_n_q;
    logic          link_s_q;
    port_oh_t      fresh_route;
    port_oh_t      route_w;
    logic          open_w;

    croute_cfg #(.CW(CW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .locked    (open_w),
        .wr_x      (cfg_x),
        .wr_y      (cfg_y),
        .wr_link_n (cfg_link_n),
        .wr_link_s (cfg_link_s),
        .cur_x     (cur_x),
        .cur_y     (cur_y),
        .link_n    (link_n_q),
        .link_s    (link_s_q)
    );

    croute_decide #(.CW(CW)) u_decide (
        .dst_x  (flit_dst_x),
        .dst_y  (flit_dst_y),
        .cur_x  (cur_x),
        .cur_y  (cur_y),
        .link_n (link_n_q),
        .link_s (link_s_q),
        .route  (fresh_route)
    );

    croute_hold u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .flit_valid  (flit_valid),
        .flit_ready  (flit_ready),
        .flit_kind   (flit_kind),
        .fresh_route (fresh_route),
        .route_oh    (route_w),
        .route_valid (route_valid),
        .open        (open_w)
    );

    assign route_oh = route_w;
    assign pkt_open = open_w;

endmodule

// File: rtl/croute_chk.sv
module croute_chk #(
    parameter int unsigned CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic          flit_valid,
    input logic          flit_ready,
    input logic [1:0]    flit_kind,
    input logic [CW-1:0] dst_x,
    input logic [CW-1:0] dst_y,
    input logic [CW-1:0] cur_x,
    input logic [CW-1:0] cur_y,
    input logic          link_n,
    input logic          link_s,
    input logic [4:0]    route_oh,
    input logic          route_valid,
    input logic          pkt_open
);

    // R1
    south_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (route_valid && !pkt_open && dst_y < cur_y && link_s) |-> route_oh == 5'b00010);

    // R4
    local_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (route_valid && !pkt_open && dst_x == cur_x && dst_y == cur_y) |-> route_oh == 5'b10000);

    // R5
    route_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        route_valid |-> $countones(route_oh) == 1);

    // R5
    orphan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pkt_open && flit_valid && !flit_kind[0]) |-> !route_valid);

    // R6
    held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_open && $past(pkt_open) && route_valid && $past(route_valid)) |-> $stable(route_oh));

    // R7
    tail_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_open && flit_valid && flit_ready && flit_kind[1]) |=> !pkt_open);

    // R8
    solo_no_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pkt_open && flit_valid && flit_kind == 2'b11) |=> !pkt_open);

    // R9
    cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_open && cfg_we) |=> ($stable(cur_x) && $stable(cur_y) && $stable(link_n) && $stable(link_s)));

endmodule

bind conn_route_unit croute_chk #(.CW(CW)) u_croute_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .flit_valid  (flit_valid),
    .flit_ready  (flit_ready),
    .flit_kind   (flit_kind),
    .dst_x       (flit_dst_x),
    .dst_y       (flit_dst_y),
    .cur_x       (cur_x),
    .cur_y       (cur_y),
    .link_n      (link_n_q),
    .link_s      (link_s_q),
    .route_oh    (route_oh),
    .route_valid (route_valid),
    .pkt_open    (pkt_open)
);

// File: tb/test_conn_route_unit.sv
`timescale 1ns/1ps
module test_conn_route_unit;

    localparam int CW = 4;
    localparam logic [4:0] P_N = 5'b00001, P_S = 5'b00010, P_E = 5'b00100,
                           P_W = 5'b01000, P_L = 5'b10000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [CW-1:0] cfg_x = '0, cfg_y = '0;
    logic cfg_link_n = 1'b0, cfg_link_s = 1'b0;
    logic flit_valid = 1'b0, flit_ready = 1'b1;
    logic [1:0] flit_kind = 2'b00;
    logic [CW-1:0] flit_dst_x = '0, flit_dst_y = '0;
    logic [4:0] route_oh;
    logic route_valid, pkt_open;

    int nvec = 0;
    int nbad = 0;
    logic [4:0] got_r;
    logic got_v;

    always #4 clk = ~clk;

    conn_route_unit #(.CW(CW)) i_conn_route_unit (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_x(cfg_x), .cfg_y(cfg_y),
        .cfg_link_n(cfg_link_n), .cfg_link_s(cfg_link_s), .flit_valid(flit_valid),
        .flit_ready(flit_ready), .flit_kind(flit_kind), .flit_dst_x(flit_dst_x),
        .flit_dst_y(flit_dst_y), .route_oh(route_oh), .route_valid(route_valid),
        .pkt_open(pkt_open)
    );

    task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic bit in_mask(input int x, input int y);
        if (x < 0 || y < 0 || x > 5 || y > 5) return 1'b0;
        if (x < 2 && y < 2) return 1'b0;
        if (x > 3 && y > 4) return 1'b0;
        if (x == 5 && y == 0) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [4:0] exp_route(input int cx, input int cy, input int dx,
                                             input int dy, input bit ln, input bit ls);
        if (dy < cy && ls) return P_S;
        if (dy > cy && ln) return P_N;
        if (dx > cx) return P_E;
        if (dx < cx) return P_W;
        if (dy < cy) return P_S;
        if (dy > cy) return P_N;
        return P_L;
    endfunction

    function automatic string tag_of(input logic [4:0] r, input int cx, input int dx);
        if (r == P_S || r == P_N) return (cx == dx) ? "R4" : "R1/R2";
        if (r == P_E || r == P_W) return "R3";
        return "R4";
    endfunction

    // called at a negedge, returns at the next negedge
    task automatic cfg_write(input int x, input int y, input bit ln, input bit ls);
        cfg_we = 1'b1;
        cfg_x = CW'(x); cfg_y = CW'(y);
        cfg_link_n = ln; cfg_link_s = ls;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [1:0] kind, input int dx, input int dy, input bit rdy);
        flit_valid = 1'b1; flit_ready = rdy; flit_kind = kind;
        flit_dst_x = CW'(dx); flit_dst_y = CW'(dy);
        #2;
        got_r = route_oh; got_v = route_valid;
        @(negedge clk);
        flit_valid = 1'b0; flit_ready = 1'b1;
    endtask

    initial begin : watchdog
        #1500000;
        nbad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 open", {5'b0, pkt_open}, 6'd0);
        chk("R10 valid", {5'b0, route_valid}, 6'd0);
        send(2'b11, 0, 0, 1'b1);
        chk("R10 coords zero -> local", {got_v, got_r}, {1'b1, P_L});
        send(2'b11, 0, 3, 1'b1);
        chk("R10 links zero -> north fallback", {got_v, got_r}, {1'b1, P_N});

        // R5 orphan body/tail
        send(2'b00, 3, 3, 1'b1);
        chk("R5 idle body", {got_v, got_r}, 6'd0);
        send(2'b10, 3, 3, 1'b1);
        chk("R5 idle tail", {got_v, got_r}, 6'd0);

        // R6/R7 held route
        cfg_write(2, 2, 1'b1, 1'b1);
        send(2'b01, 5, 2, 1'b1);
        chk("R6 head east", {got_v, got_r}, {1'b1, P_E});
        chk("R6 opens", {5'b0, pkt_open}, 6'd1);
        send(2'b00, 0, 0, 1'b1);
        chk("R6 body held", {got_v, got_r}, {1'b1, P_E});
        send(2'b01, 2, 2, 1'b1);
        chk("R6 head inside packet held", {got_v, got_r}, {1'b1, P_E});
        #2;
        chk("R5 no flit no route", {5'b0, route_valid}, 6'd0);
        @(negedge clk);
        // R9 write while open ignored
        cfg_write(7, 7, 1'b0, 1'b0);
        send(2'b10, 9, 9, 1'b0);
        chk("R7 unaccepted tail held", {got_v, got_r}, {1'b1, P_E});
        chk("R7 unaccepted tail keeps open", {5'b0, pkt_open}, 6'd1);
        send(2'b10, 9, 9, 1'b1);
        chk("R7 tail held", {got_v, got_r}, {1'b1, P_E});
        chk("R7 tail closes", {5'b0, pkt_open}, 6'd0);
        send(2'b11, 2, 2, 1'b1);
        chk("R9 locked write ignored", {got_v, got_r}, {1'b1, P_L});

        // R8
        send(2'b01, 2, 0, 1'b0);
        chk("R8 unaccepted head routed", {got_v, got_r}, {1'b1, P_S});
        chk("R8 unaccepted head no open", {5'b0, pkt_open}, 6'd0);
        send(2'b11, 2, 0, 1'b1);
        chk("R8 solo no open", {5'b0, pkt_open}, 6'd0);
        send(2'b01, 2, 0, 1'b1);
        send(2'b11, 0, 0, 1'b1);
        chk("R7 solo closes", {5'b0, pkt_open}, 6'd0);

        // R9 idle write applies
        cfg_write(7, 7, 1'b0, 1'b0);
        send(2'b11, 2, 2, 1'b1);
        chk("R9 idle write -> west", {got_v, got_r}, {1'b1, P_W});

        // near-exhaustive sweep of decisions
        for (int c = 0; c < 3; c++) begin
            for (int lk = 0; lk < 4; lk++) begin
                int cx, cy;
                cx = (c == 0) ? 0 : (c == 1) ? 7 : 15;
                cy = (c == 0) ? 15 : (c == 1) ? 8 : 0;
                cfg_write(cx, cy, lk[1], lk[0]);
                for (int dx = 0; dx < 16; dx++) begin
                    for (int dy = 0; dy < 16; dy++) begin
                        logic [4:0] e;
                        e = exp_route(cx, cy, dx, dy, lk[1], lk[0]);
                        send(2'b11, dx, dy, 1'b1);
                        chk(tag_of(e, cx, dx), {got_v, got_r}, {1'b1, e});
                    end
                end
            end
        end

        // R11 walk every pair of the convex region
        for (int sx = 0; sx < 6; sx++) for (int sy = 0; sy < 6; sy++)
        for (int dx = 0; dx < 6; dx++) for (int dy = 0; dy < 6; dy++) begin
            if (in_mask(sx, sy) && in_mask(dx, dy)) begin
                int cx, cy, hops;
                bit done, lost;
                cx = sx; cy = sy; hops = 0; done = 0; lost = 0;
                while (!done && !lost && hops < 20) begin
                    bit ln, ls;
                    logic [4:0] e;
                    ln = in_mask(cx, cy + 1);
                    ls = in_mask(cx, cy - 1);
                    cfg_write(cx, cy, ln, ls);
                    send(2'b11, dx, dy, 1'b1);
                    e = exp_route(cx, cy, dx, dy, ln, ls);
                    chk(tag_of(e, cx, dx), {got_v, got_r}, {1'b1, e});
                    case (got_r)
                        P_N: cy++;
                        P_S: cy--;
                        P_E: cx++;
                        P_W: cx--;
                        P_L: done = 1;
                        default: lost = 1;
                    endcase
                    if (!done && !lost) begin
                        hops++;
                        if (!in_mask(cx, cy)) begin
                            lost = 1;
                            chk("R11 hop inside region", 6'd0, 6'd1);
                        end
                    end
                end
                chk("R11 reached destination", {5'b0, (cx == dx && cy == dy)}, 6'd1);
                chk("R11 hops equal Manhattan", 6'(hops),
                    6'((sx > dx ? sx - dx : dx - sx) + (sy > dy ? sy - dy : dy - sy)));
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule